// File: doc/BRIEF.md
# Elapsed-Time Clock with Interval Alarm

This block keeps a running time of day in four cascaded registers: fractions of a second in 1/128 s steps, seconds, minutes and hours. It takes a 32.768 kHz enable pulse and divides it down to a 128 Hz step. A run control starts and stops this clock. Software can load any of the four time fields through a plain write port.

Beside the clock sits an interval alarm. Software picks one unit of time (1/128 s, second, minute or hour) and a count. The alarm counter moves on each step of that unit and raises a sticky flag when it reaches the programmed count. In reload mode the counter then starts again from zero. In one-shot mode it stops at the count until the alarm is disabled. Disabling the alarm clears its counter.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: While reset is held, all four time fields, the alarm counter and the alarm flag become 0.
- R2: While `clk_run` is 1, the fraction field advances once for every PRESCALE (default 256) clock cycles on which `osc_en` is 1. While `clk_run` is 0, the divider is held at zero, so the next step comes a full PRESCALE enabled cycles after `clk_run` returns to 1.
- R3: The fraction field counts 0..127, seconds 0..59, minutes 0..59 and hours 0..255. Each field wraps to 0 on the step after its top value and advances the next field on that same step. A field loaded above its top value also wraps to 0, with a carry, on its next step.
- R4: While `clk_run` is 0, no time field changes except through a write.
- R5: With `wr_en` at 1, the field selected by `wr_sel` (0 fraction, 1 seconds, 2 minutes, 3 hours) takes the low bits of `wr_data` that fit its width (7, 6, 6, 8) on the next clock edge. A write wins over any step of that field in the same cycle.
- R6: `unit_sel` picks the alarm unit: 0 = every fraction step, 1 = every seconds step, 2 = every minutes step, 3 = every hours step.
- R7: While `alarm_en` is 1, the alarm counter moves up by one on each step of the selected unit. When the new value equals `interval_val`, the flag is set. A value of 0 means 256 units.
- R8: With `one_shot` at 0, the counter goes to 0 on the step that sets the flag, and it goes on counting toward the next match.
- R9: With `one_shot` at 1, the counter stays at the matching value after the match. Later unit steps neither move it nor set the flag again until `alarm_en` has been 0.
- R10: `alarm_en` at 0 forces the counter to 0, ends the one-shot stop and never sets the flag.
- R11: The flag stays set until `flag_clr` is 1. A set in the same cycle as a clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| clk_run | input | 1 | Runs the time fields and the divider |
| wr_en | input | 1 | Write strobe for a time field |
| wr_sel | input | 2 | Field to write: 0 fraction, 1 s, 2 min, 3 h |
| wr_data | input | 8 | Value written to the selected field |
| alarm_en | input | 1 | Enables the alarm counter; 0 clears it |
| one_shot | input | 1 | 1 = stop after one match, 0 = reload and restart |
| unit_sel | input | 2 | Alarm unit: 0 1/128 s, 1 s, 2 min, 3 h |
| interval_val | input | 8 | Number of units per alarm (0 = 256) |
| flag_clr | input | 1 | Clears the alarm flag |
| frac_q | output | 7 | Elapsed 1/128 s field |
| sec_q | output | 6 | Elapsed seconds field |
| min_q | output | 6 | Elapsed minutes field |
| hour_q | output | 8 | Elapsed hours field |
| alarm_cnt_q | output | 8 | Alarm counter |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
A divider phase error moves the first fraction step off its expected cycle. It therefore shows on `frac_q` within one divider period of the fault. A wrong carry shows on the next field in the very cycle a field wraps, so the bench loads every field next to its top value instead of waiting for it. An alarm counter that drifts or misses a reload shows on `alarm_cnt_q` at the next unit step, and on `alarm_flag` at the next match. The bench compares all outputs with a behavioural model after every clock, so a fault is reported in the cycle it first reaches a port.

// File: rtl/eat_pkg.sv
// Package for the elapsed-time clock with interval alarm.
// Holds the unit encoding for the alarm timebase and small helpers.
package eat_pkg;

    // Alarm unit: which field's step advances the alarm counter
    typedef enum logic [1:0] {
        UNIT_FRAC = 2'd0,
        UNIT_SEC  = 2'd1,
        UNIT_MIN  = 2'd2,
        UNIT_HOUR = 2'd3
    } unit_e;

    localparam int NUM_FIELDS = 4;

    // Bits needed to hold values 0..top
    function automatic int field_width(input int top);
        return $clog2(top + 1);
    endfunction

endpackage

// File: rtl/eat_prescaler.sv
// Divides a slow enable pulse into a one-cycle step pulse.
// Assumes PRESCALE >= 2. The count is held at zero while run is low.
module eat_prescaler #(
    parameter int PRESCALE = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_en,
    output logic tick
);
    localparam int PW = $clog2(PRESCALE);
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    // Step pulse on the last enabled cycle of each division period
    assign tick = run && osc_en && (div_q == LAST);

    // Division counter, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (osc_en) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/eat_stage.sv
// One field of the time chain: counts to TOP, wraps to zero on the next step.
// Assumes TOP fits in W bits. A load wins over a step in the same cycle.
module eat_stage #(
    parameter int W   = 8,
    parameter int TOP = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q,
    output logic         at_top
);
    // At or beyond the top value: the next step wraps and carries
    assign at_top = (q >= W'(TOP));

    // Field register with load priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (inc) begin
            q <= at_top ? '0 : q + 1'b1;
        end
    end
endmodule

// File: rtl/eat_time_chain.sv
// Four cascaded time fields (fraction, seconds, minutes, hours).
// Assumes every field top fits in W bits. steps[i] is high in the cycle field i advances.
module eat_time_chain
    import eat_pkg::*;
#(
    parameter int W        = 8,
    parameter int FRAC_TOP = 127,
    parameter int SEC_TOP  = 59,
    parameter int MIN_TOP  = 59,
    parameter int HOUR_TOP = 255
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [W-1:0]               wr_data,
    output logic [NUM_FIELDS-1:0][W-1:0] vals,
    output logic [NUM_FIELDS-1:0]      steps
);
    logic [NUM_FIELDS-1:0] at_top;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_stage
        localparam int TOP_I = (i == 0) ? FRAC_TOP :
                               (i == 1) ? SEC_TOP  :
                               (i == 2) ? MIN_TOP  : HOUR_TOP;
        localparam int FW_I = field_width(TOP_I);
        localparam logic [W-1:0] MASK_I = W'((1 << FW_I) - 1);

        logic inc_i;
        logic ld_i;

        // A field steps when the base tick arrives and every lower field wraps
        if (i == 0) begin : g_first
            assign inc_i = tick;
        end else begin : g_upper
            assign inc_i = tick & (&at_top[i-1:0]);
        end

        assign ld_i     = wr_en && (wr_sel == 2'(i));
        assign steps[i] = inc_i;

        eat_stage #(
            .W   (W),
            .TOP (TOP_I)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_i),
            .ld     (ld_i),
            .ld_val (wr_data & MASK_I),
            .q      (vals[i]),
            .at_top (at_top[i])
        );
    end
endmodule

// File: rtl/eat_interval.sv
// Alarm counter and sticky flag for the interval alarm.
// Assumes unit_step is a one-cycle pulse. A limit of zero matches after 2**CW steps.
module eat_interval #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          one_shot,
    input  logic          unit_step,
    input  logic [CW-1:0] limit,
    input  logic          flag_clr,
    output logic [CW-1:0] cnt_q,
    output logic          flag_q
);
    logic          done_q;
    logic [CW-1:0] cnt_nxt;
    logic          hit;

    assign cnt_nxt = cnt_q + 1'b1;
    assign hit     = en && unit_step && !done_q && (cnt_nxt == limit);

    // Counter and one-shot stop state
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (unit_step && !done_q) begin
            if (cnt_nxt == limit) begin
                cnt_q  <= one_shot ? cnt_nxt : '0;
                done_q <= one_shot;
            end else begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // Sticky flag: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/elapsed_alarm_timer.sv
// Elapsed-time clock with a selectable-unit interval alarm.
// Assumes osc_en is a one-cycle pulse and every field top fits in DATA_W bits.
module elapsed_alarm_timer
    import eat_pkg::*;
#(
    parameter int PRESCALE = 256,
    parameter int FRAC_TOP = 127,
    parameter int SEC_TOP  = 59,
    parameter int MIN_TOP  = 59,
    parameter int HOUR_TOP = 255,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 osc_en,
    input  logic                                 clk_run,
    input  logic                                 wr_en,
    input  logic [1:0]                           wr_sel,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 alarm_en,
    input  logic                                 one_shot,
    input  logic [1:0]                           unit_sel,
    input  logic [CNT_W-1:0]                     interval_val,
    input  logic                                 flag_clr,
    output logic [$clog2(FRAC_TOP+1)-1:0]        frac_q,
    output logic [$clog2(SEC_TOP+1)-1:0]         sec_q,
    output logic [$clog2(MIN_TOP+1)-1:0]         min_q,
    output logic [$clog2(HOUR_TOP+1)-1:0]        hour_q,
    output logic [CNT_W-1:0]                     alarm_cnt_q,
    output logic                                 alarm_flag
);
    localparam int FRAC_W = field_width(FRAC_TOP);
    localparam int SEC_W  = field_width(SEC_TOP);
    localparam int MIN_W  = field_width(MIN_TOP);
    localparam int HOUR_W = field_width(HOUR_TOP);

    logic                             tick;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] vals;
    logic [NUM_FIELDS-1:0]            steps;
    logic                             unit_step;

    eat_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (clk_run),
        .osc_en (osc_en),
        .tick   (tick)
    );

    eat_time_chain #(
        .W        (DATA_W),
        .FRAC_TOP (FRAC_TOP),
        .SEC_TOP  (SEC_TOP),
        .MIN_TOP  (MIN_TOP),
        .HOUR_TOP (HOUR_TOP)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .vals    (vals),
        .steps   (steps)
    );

    // Pick the step pulse of the selected alarm unit
    always_comb begin
        case (unit_e'(unit_sel))
            UNIT_FRAC: unit_step = steps[0];
            UNIT_SEC:  unit_step = steps[1];
            UNIT_MIN:  unit_step = steps[2];
            default:   unit_step = steps[3];
        endcase
    end

    eat_interval #(
        .CW (CNT_W)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (alarm_en),
        .one_shot  (one_shot),
        .unit_step (unit_step),
        .limit     (interval_val),
        .flag_clr  (flag_clr),
        .cnt_q     (alarm_cnt_q),
        .flag_q    (alarm_flag)
    );

    assign frac_q = vals[0][FRAC_W-1:0];
    assign sec_q  = vals[1][SEC_W-1:0];
    assign min_q  = vals[2][MIN_W-1:0];
    assign hour_q = vals[3][HOUR_W-1:0];
endmodule

// File: rtl/eat_checker.sv
// Port-level properties for elapsed_alarm_timer, attached by bind below.
// Assumes the synchronous active-low reset of the target.
module eat_checker #(
    parameter int FRAC_TOP = 127,
    parameter int SEC_TOP  = 59,
    parameter int MIN_TOP  = 59,
    parameter int HOUR_TOP = 255,
    parameter int CNT_W    = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          clk_run,
    input logic                          wr_en,
    input logic                          alarm_en,
    input logic                          flag_clr,
    input logic [$clog2(FRAC_TOP+1)-1:0] frac_q,
    input logic [$clog2(SEC_TOP+1)-1:0]  sec_q,
    input logic [$clog2(MIN_TOP+1)-1:0]  min_q,
    input logic [$clog2(HOUR_TOP+1)-1:0] hour_q,
    input logic [CNT_W-1:0]              alarm_cnt_q,
    input logic                          alarm_flag
);
    localparam int FRAC_W = $clog2(FRAC_TOP + 1);

    logic [CNT_W-1:0]  cnt_prev;
    logic [FRAC_W-1:0] frac_prev;

    // Previous-cycle copies of the alarm counter and fraction field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_prev  <= '0;
            frac_prev <= '0;
        end else begin
            cnt_prev  <= alarm_cnt_q;
            frac_prev <= frac_q;
        end
    end

    // R4: a stopped clock without a write keeps every field
    a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_run && !wr_en) |=> ($stable(frac_q) && $stable(sec_q) &&
                                  $stable(min_q) && $stable(hour_q)));

    // R3: without a write the fraction holds, steps by one or wraps to zero
    a_r3_frac_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (frac_q == frac_prev || frac_q == FRAC_W'(frac_prev + 1'b1) ||
                    frac_q == '0));

    // R7: the alarm counter holds, steps by one or returns to zero
    a_r7_counter_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en |=> (alarm_cnt_q == cnt_prev || alarm_cnt_q == CNT_W'(cnt_prev + 1'b1) ||
                      alarm_cnt_q == '0));

    // R10: a disabled alarm clears its counter
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |=> (alarm_cnt_q == '0));

    // R10: a disabled alarm never raises the flag
    a_r10_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && !alarm_flag) |=> !alarm_flag);

    // R11: the flag stays set until a clear
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag);
endmodule

bind elapsed_alarm_timer eat_checker #(
    .FRAC_TOP (FRAC_TOP),
    .SEC_TOP  (SEC_TOP),
    .MIN_TOP  (MIN_TOP),
    .HOUR_TOP (HOUR_TOP),
    .CNT_W    (CNT_W)
) u_eat_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_run     (clk_run),
    .wr_en       (wr_en),
    .alarm_en    (alarm_en),
    .flag_clr    (flag_clr),
    .frac_q      (frac_q),
    .sec_q       (sec_q),
    .min_q       (min_q),
    .hour_q      (hour_q),
    .alarm_cnt_q (alarm_cnt_q),
    .alarm_flag  (alarm_flag)
);

// File: tb/elapsed_alarm_timer_tb_top.sv
// Bench for elapsed_alarm_timer: directed stimulus, a behavioural model
// compared after every clock, and directed checks at chosen cycles.
module elapsed_alarm_timer_tb_top;
    localparam int PS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       clk_run = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       alarm_en = 1'b0;
    logic       one_shot = 1'b0;
    logic [1:0] unit_sel = 2'd0;
    logic [7:0] interval_val = 8'd0;
    logic       flag_clr = 1'b0;
    logic [6:0] frac_q;
    logic [5:0] sec_q;
    logic [5:0] min_q;
    logic [7:0] hour_q;
    logic [7:0] alarm_cnt_q;
    logic       alarm_flag;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Behavioural model state
    int m_ps, m_f, m_s, m_m, m_h, m_cnt, m_flag;
    bit m_stop;

    elapsed_alarm_timer #(.PRESCALE(PS)) dut_i (
        .clk (clk), .rst_n (rst_n), .osc_en (osc_en), .clk_run (clk_run),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .alarm_en (alarm_en), .one_shot (one_shot), .unit_sel (unit_sel),
        .interval_val (interval_val), .flag_clr (flag_clr),
        .frac_q (frac_q), .sec_q (sec_q), .min_q (min_q), .hour_q (hour_q),
        .alarm_cnt_q (alarm_cnt_q), .alarm_flag (alarm_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model, one update per rising edge
    always @(posedge clk) begin
        bit tick, c0, c1, c2, ev;
        int nxt;
        cyc++;
        if (!rst_n) begin
            m_ps = 0; m_f = 0; m_s = 0; m_m = 0; m_h = 0;
            m_cnt = 0; m_flag = 0; m_stop = 0;
        end else begin
            tick = 0;
            if (!clk_run) m_ps = 0;
            else if (osc_en) begin
                if (m_ps == PS - 1) begin m_ps = 0; tick = 1; end
                else m_ps++;
            end
            c0 = tick && (m_f >= 127);
            c1 = c0 && (m_s >= 59);
            c2 = c1 && (m_m >= 59);
            if (tick) m_f = (m_f >= 127) ? 0 : m_f + 1;
            if (c0)   m_s = (m_s >= 59) ? 0 : m_s + 1;
            if (c1)   m_m = (m_m >= 59) ? 0 : m_m + 1;
            if (c2)   m_h = (m_h + 1) % 256;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_f = wr_data & 127;
                    2'd1: m_s = wr_data & 63;
                    2'd2: m_m = wr_data & 63;
                    default: m_h = wr_data;
                endcase
            end
            case (unit_sel)
                2'd0: ev = tick;
                2'd1: ev = c0;
                2'd2: ev = c1;
                default: ev = c2;
            endcase
            if (!alarm_en) begin
                m_cnt = 0; m_stop = 0;
                if (flag_clr) m_flag = 0;
            end else begin
                if (ev && !m_stop) begin
                    nxt = (m_cnt + 1) % 256;
                    if (nxt == interval_val) begin
                        m_flag = 1;
                        if (one_shot) begin m_cnt = nxt; m_stop = 1; end
                        else m_cnt = 0;
                    end else begin
                        m_cnt = nxt;
                        if (flag_clr) m_flag = 0;
                    end
                end else if (flag_clr) m_flag = 0;
            end
        end
    end

    // Compare every output with the model between edges
    always @(negedge clk) begin
        if (cyc > 1 && !done) begin
            chk("R3 frac", int'(frac_q), m_f);
            chk("R3 sec", int'(sec_q), m_s);
            chk("R3 min", int'(min_q), m_m);
            chk("R3 hour", int'(hour_q), m_h);
            chk("R7 alarm count", int'(alarm_cnt_q), m_cnt);
            chk("R11 alarm flag", int'(alarm_flag), m_flag);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
        step(1);
        wr_en = 1'b0;
    endtask

    // Stop the clock for one cycle so the divider restarts from zero
    task automatic halt();
        clk_run = 1'b0;
        step(1);
    endtask

    initial begin
        osc_en = 1'b1;
        step(3);
        // R1: reset values
        chk("R1 frac", int'(frac_q), 0);
        chk("R1 hour", int'(hour_q), 0);
        chk("R1 count", int'(alarm_cnt_q), 0);
        chk("R1 flag", int'(alarm_flag), 0);
        rst_n = 1'b1;
        step(1);

        // R2: first step after PS enabled cycles
        clk_run = 1'b1;
        step(PS - 1);
        chk("R2 before step", int'(frac_q), 0);
        step(1);
        chk("R2 at step", int'(frac_q), 1);
        osc_en = 1'b0;
        step(20);
        chk("R2 no enable", int'(frac_q), 1);
        for (int i = 0; i < 200; i++) begin
            osc_en = (i % 3 != 0);
            step(1);
        end
        osc_en = 1'b1;

        // R5: loads, with truncation to the field width
        halt();
        wr(0, 255);
        chk("R5 frac truncated", int'(frac_q), 127);
        wr(1, 59);
        wr(2, 59);
        wr(3, 255);
        chk("R5 sec", int'(sec_q), 59);
        chk("R5 min", int'(min_q), 59);
        chk("R5 hour", int'(hour_q), 255);

        // R4: stopped clock holds
        step(40);
        chk("R4 frozen frac", int'(frac_q), 127);
        chk("R4 frozen sec", int'(sec_q), 59);

        // R3: full wrap of every field
        clk_run = 1'b1;
        step(PS);
        chk("R3 wrap frac", int'(frac_q), 0);
        chk("R3 wrap sec", int'(sec_q), 0);
        chk("R3 wrap min", int'(min_q), 0);
        chk("R3 wrap hour", int'(hour_q), 0);

        // R3: field loaded above its top wraps with a carry
        halt();
        wr(1, 63);
        wr(0, 127);
        clk_run = 1'b1;
        step(PS);
        chk("R3 over-top sec", int'(sec_q), 0);
        chk("R3 over-top carry", int'(min_q), 1);

        // R6 unit 0, R8 reload with interval 3
        halt();
        unit_sel = 2'd0; interval_val = 8'd3; one_shot = 1'b0;
        alarm_en = 1'b1; clk_run = 1'b1;
        step(3 * PS - 1);
        chk("R7 count before match", int'(alarm_cnt_q), 2);
        chk("R7 flag before match", int'(alarm_flag), 0);
        step(1);
        chk("R7 flag at match", int'(alarm_flag), 1);
        chk("R8 reload to zero", int'(alarm_cnt_q), 0);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R11 clear", int'(alarm_flag), 0);
        step(6 * PS);

        // R9: one-shot on seconds
        halt();
        alarm_en = 1'b0;
        step(1);
        chk("R10 disable clears", int'(alarm_cnt_q), 0);
        wr(0, 126);
        unit_sel = 2'd1; interval_val = 8'd1; one_shot = 1'b1;
        alarm_en = 1'b1; clk_run = 1'b1;
        step(2 * PS);
        chk("R6 second unit flag", int'(alarm_flag), 1);
        chk("R9 holds match", int'(alarm_cnt_q), 1);
        step(128 * PS);
        chk("R9 stopped count", int'(alarm_cnt_q), 1);
        chk("R11 sticky", int'(alarm_flag), 1);
        alarm_en = 1'b0;
        step(1);
        chk("R10 count cleared", int'(alarm_cnt_q), 0);
        chk("R10 flag kept", int'(alarm_flag), 1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R11 cleared", int'(alarm_flag), 0);

        // R6: minute and hour units
        halt();
        wr(1, 59); wr(0, 127);
        unit_sel = 2'd2; interval_val = 8'd1; one_shot = 1'b0; alarm_en = 1'b1;
        clk_run = 1'b1;
        step(PS);
        chk("R6 minute unit", int'(alarm_flag), 1);
        chk("R8 minute reload", int'(alarm_cnt_q), 0);
        halt();
        flag_clr = 1'b1; alarm_en = 1'b0; step(1); flag_clr = 1'b0;
        wr(2, 59); wr(1, 59); wr(0, 127);
        unit_sel = 2'd3; alarm_en = 1'b1; clk_run = 1'b1;
        step(PS - 1);
        chk("R6 hour unit early", int'(alarm_flag), 0);
        step(1);
        chk("R6 hour unit", int'(alarm_flag), 1);

        // R11: set wins over a simultaneous clear
        halt();
        unit_sel = 2'd0; interval_val = 8'd1;
        flag_clr = 1'b1; clk_run = 1'b1;
        step(PS - 1);
        chk("R11 cleared while waiting", int'(alarm_flag), 0);
        step(1);
        chk("R11 set wins", int'(alarm_flag), 1);
        flag_clr = 1'b0;

        // R7: interval 0 means 256 units
        halt();
        flag_clr = 1'b1; alarm_en = 1'b0; step(1); flag_clr = 1'b0;
        interval_val = 8'd0; alarm_en = 1'b1; clk_run = 1'b1;
        step(256 * PS - 1);
        chk("R7 count 255", int'(alarm_cnt_q), 255);
        chk("R7 no flag yet", int'(alarm_flag), 0);
        step(1);
        chk("R7 flag after 256", int'(alarm_flag), 1);
        chk("R7 wraps to zero", int'(alarm_cnt_q), 0);
        step(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule